// File: doc/BRIEF.md
# Configurable Interrupt Status Register

This block holds a row of interrupt status bits, one per event source. Every bit watches its own trigger input and, at elaboration time, is given one of four trigger kinds (level, rising edge, falling edge, both edges). It is also either latching or transparent. A latching bit records an event and keeps it until software clears it. A transparent bit follows its set condition from cycle to cycle.

Software reaches the bits through a plain write port with per-byte enables. It sees their value on the `status` output. Writing a one clears a latching bit. Each bit is qualified twice. Its `qual` input acts as a blocking mask or as a passing enable, depending on how the bit is built, and the result drives the aggregate `irq` output. A separate `halt_mask` input gates the bit onto the aggregate `halt` output. Both aggregate outputs are combinational functions of the status flops and the qualifying inputs.

Top module: `isr_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every status bit and every trigger history flop to 0. A rising or both-edge bit whose trigger is already 1 when reset is released therefore sets on the first clock after release.
- R2: A rising-edge bit (kind code 1) sets when its trigger was 0 at the previous clock and is 1 at this clock. The new status is visible after this clock.
- R3: A falling-edge bit (kind code 2) sets when its trigger was 1 at the previous clock and is 0 at this clock.
- R4: A both-edge bit (kind code 3) sets whenever its trigger differs from its value at the previous clock.
- R5: A level bit (kind code 0) sets at any clock at which its trigger is 1, with no history.
- R6: A latching bit (its `STICKY` parameter bit is 1) stays 1 until software clears it, whatever its trigger does.
- R7: A transparent bit (its `STICKY` bit is 0) takes the value of its set condition at every clock. Software writes have no effect on it.
- R8: A write with `wr_en`=1 clears every latching bit i whose `wr_data[i]` is 1 and whose byte enable `wr_be[i/8]` is 1. No other bit is changed by the write.
- R9: When a set condition and a software clear hit the same latching bit at the same clock, the bit ends up 1.
- R10: `irq` is the OR of the qualified status bits. A bit whose `QUAL_ENABLE` parameter bit is 1 passes when its `qual` input is 1. A bit whose `QUAL_ENABLE` bit is 0 is blocked when its `qual` input is 1.
- R11: `halt` is the OR of the status bits whose `halt_mask` input is 0.
- R12: `irq` and `halt` follow a change of `qual` or `halt_mask` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | N | Per-bit trigger inputs |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | N | Write data; a 1 clears the matching latching bit |
| wr_be | input | (N+7)/8 | Byte enables for the write |
| qual | input | N | Per-bit mask or enable, depending on QUAL_ENABLE |
| halt_mask | input | N | Per-bit halt blocking inputs |
| status | output | N | Current status bits |
| irq | output | 1 | Aggregate qualified interrupt |
| halt | output | 1 | Aggregate halt request |

## Verification
The bench holds triggers high across reset release. A design that reset only the status flops, and not the history flops, would miss the first rising edge. It also lines up a set condition with a software clear at the same clock. A design that gave the clear priority would drop that event. Writes whose byte enable is low are also issued. A design that ignored `wr_be` would clear bits in the disabled byte. Bits of both qualifier polarities are driven with `qual` both low and high. A design that treated every qualifier alike would raise `irq` with the wrong sense on one of the two halves.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_kind_e;

    typedef struct packed {
        logic set;
        logic clr;
    } bit_ctl_t;

    function automatic logic set_cond(trig_kind_e kind, logic cur, logic prev);
        logic r;
        case (kind)
            TRIG_LEVEL: r = cur;
            TRIG_RISE:  r = cur & ~prev;
            TRIG_FALL:  r = ~cur & prev;
            default:    r = cur ^ prev;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/isr_edge_detect.sv
module isr_edge_detect
    import isr_pkg::*;
#(
    parameter trig_kind_e KIND = TRIG_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic set_o
);

    // History flop; unused (and removed by synthesis) for level bits.
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= trig_i;
    end

    assign set_o = set_cond(KIND, trig_i, prev_q);

endmodule

// File: rtl/isr_status_bit.sv
module isr_status_bit
    import isr_pkg::*;
#(
    parameter bit STICKY = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_ctl_t ctl_i,
    output logic     status_o
);

    logic status_q;
    logic status_d;

    always_comb begin
        if (STICKY) status_d = ctl_i.set | (status_q & ~ctl_i.clr);
        else        status_d = ctl_i.set;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= status_d;
    end

    assign status_o = status_q;

endmodule

// File: rtl/isr_aggregate.sv
module isr_aggregate #(
    parameter int          N           = 16,
    parameter logic [N-1:0] QUAL_ENABLE = '0
) (
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] qual_i,
    input  logic [N-1:0] halt_mask_i,
    output logic         irq_o,
    output logic         halt_o
);

    logic [N-1:0] pass;

    for (genvar i = 0; i < N; i++) begin : g_pass
        if (QUAL_ENABLE[i]) begin : g_en
            assign pass[i] = qual_i[i];
        end else begin : g_mask
            assign pass[i] = ~qual_i[i];
        end
    end

    assign irq_o  = |(status_i & pass);
    assign halt_o = |(status_i & ~halt_mask_i);

endmodule

// File: rtl/isr_status_reg.sv
module isr_status_reg
    import isr_pkg::*;
#(
    parameter int             N           = 16,
    parameter logic [2*N-1:0] TRIG_KIND   = 32'hE4E4_E4E4,
    parameter logic [N-1:0]   STICKY      = 16'h0F0F,
    parameter logic [N-1:0]   QUAL_ENABLE = 16'hAAAA,
    localparam int            NBYTES      = (N + 7) / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      trig,
    input  logic              wr_en,
    input  logic [N-1:0]      wr_data,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [N-1:0]      qual,
    input  logic [N-1:0]      halt_mask,
    output logic [N-1:0]      status,
    output logic              irq,
    output logic              halt
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam trig_kind_e KIND = trig_kind_e'(TRIG_KIND[2*i +: 2]);
        bit_ctl_t ctl;

        isr_edge_detect #(.KIND(KIND)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .trig_i (trig[i]),
            .set_o  (ctl.set)
        );

        assign ctl.clr = wr_en & wr_data[i] & wr_be[i/8];

        isr_status_bit #(.STICKY(STICKY[i])) u_stat (
            .clk      (clk),
            .rst      (rst),
            .ctl_i    (ctl),
            .status_o (status[i])
        );
    end

    isr_aggregate #(.N(N), .QUAL_ENABLE(QUAL_ENABLE)) u_agg (
        .status_i    (status),
        .qual_i      (qual),
        .halt_mask_i (halt_mask),
        .irq_o       (irq),
        .halt_o      (halt)
    );

endmodule

// File: rtl/isr_status_reg_chk.sv
module isr_status_reg_chk #(
    parameter int             N           = 16,
    parameter logic [2*N-1:0] TRIG_KIND   = '0,
    parameter logic [N-1:0]   STICKY      = '0,
    localparam int            NBYTES      = (N + 7) / 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      trig,
    input logic              wr_en,
    input logic [N-1:0]      wr_data,
    input logic [NBYTES-1:0] wr_be,
    input logic [N-1:0]      halt_mask,
    input logic [N-1:0]      status,
    input logic              irq,
    input logic              halt
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> status == '0);

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> status != '0);

    // R11
    halt_fully_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (&halt_mask) |-> !halt);

    for (genvar i = 0; i < N; i++) begin : g_chk
        localparam logic [1:0] K = TRIG_KIND[2*i +: 2];

        // R2 R3 R4 R5
        if (K == 2'd0) begin : g_lvl
            trig_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
                trig[i] |=> status[i]);
        end else if (K == 2'd1) begin : g_rise
            trig_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(trig[i]) |=> status[i]);
        end else if (K == 2'd2) begin : g_fall
            trig_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(trig[i]) |=> status[i]);
        end else begin : g_both
            trig_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
                ($rose(trig[i]) || $fell(trig[i])) |=> status[i]);
        end

        if (STICKY[i]) begin : g_sticky
            // R6
            sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (status[i] && !(wr_en && wr_data[i] && wr_be[i/8])) |=> status[i]);
        end
    end

endmodule

bind isr_status_reg isr_status_reg_chk #(
    .N(N), .TRIG_KIND(TRIG_KIND), .STICKY(STICKY)
) chk_i (
    .clk(clk), .rst(rst), .trig(trig), .wr_en(wr_en), .wr_data(wr_data),
    .wr_be(wr_be), .halt_mask(halt_mask), .status(status), .irq(irq), .halt(halt)
);

// File: tb/isr_status_reg_test.sv
module isr_status_reg_test;

    localparam int             CLK_PERIOD = 10;
    localparam int             N          = 16;
    localparam int             NB         = 2;
    localparam logic [2*N-1:0] KINDS      = 32'hE4E4_E4E4;
    localparam logic [N-1:0]   STK        = 16'h0F0F;
    localparam logic [N-1:0]   QEN        = 16'hAAAA;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  trig = '0;
    logic          wr_en = 1'b0;
    logic [N-1:0]  wr_data = '0;
    logic [NB-1:0] wr_be = '0;
    logic [N-1:0]  qual = '0;
    logic [N-1:0]  halt_mask = '0;
    logic [N-1:0]  status;
    logic          irq, halt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_status_reg #(.N(N), .TRIG_KIND(KINDS), .STICKY(STK), .QUAL_ENABLE(QEN)) uut (
        .clk(clk), .rst(rst), .trig(trig), .wr_en(wr_en), .wr_data(wr_data),
        .wr_be(wr_be), .qual(qual), .halt_mask(halt_mask),
        .status(status), .irq(irq), .halt(halt)
    );

    // Reference model built from the requirements
    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_prev = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_stat <= '0;
            m_prev <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                logic s, c;
                case (KINDS[2*i +: 2])
                    2'd0: s = trig[i];
                    2'd1: s = trig[i] & ~m_prev[i];
                    2'd2: s = ~trig[i] & m_prev[i];
                    default: s = trig[i] ^ m_prev[i];
                endcase
                c = wr_en & wr_data[i] & wr_be[i/8];
                m_stat[i] <= STK[i] ? (s | (m_stat[i] & ~c)) : s;
            end
            m_prev <= trig;
        end
    end

    function automatic logic m_irq();
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) p[i] = QEN[i] ? qual[i] : ~qual[i];
        return |(m_stat & p);
    endfunction

    task automatic expect_all(string tag);
        n_chk++;
        if (status !== m_stat || irq !== m_irq() || halt !== |(m_stat & ~halt_mask)) begin
            n_bad++;
            $display("FAIL %s: status=%h irq=%b halt=%b expected status=%h irq=%b halt=%b",
                     tag, status, irq, halt, m_stat, m_irq(), |(m_stat & ~halt_mask));
        end
    endtask

    task automatic expect_bit(string tag, int idx, logic val);
        n_chk++;
        if (status[idx] !== val) begin
            n_bad++;
            $display("FAIL %s: status[%0d]=%b expected %b", tag, idx, status[idx], val);
        end
    endtask

    task automatic expect_sig(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        trig = '0; tick(2);
        wr_en = 1'b1; wr_data = '1; wr_be = '1; tick();
        wr_en = 1'b0; wr_data = '0; wr_be = '0; tick();
    endtask

    task automatic t_reset();
        trig = 16'hFFFF;
        tick(2);
        expect_all("R1 reset value");
        expect_sig("R1 irq in reset", irq, 1'b0);
        rst = 1'b0; tick();
        expect_bit("R1 rise after release", 1, 1'b1);
        expect_bit("R1 fall stays", 2, 1'b0);
        expect_all("R1 after release");
        clear_all();
        expect_all("R1 cleared");
    endtask

    task automatic t_rise();
        trig[1] = 1'b1; trig[5] = 1'b1; tick();
        expect_bit("R2 rise sticky", 1, 1'b1);
        expect_bit("R7 rise transparent pulse", 5, 1'b1);
        tick();
        expect_bit("R7 transparent drops", 5, 1'b0);
        trig[1] = 1'b0; tick(2);
        expect_bit("R6 sticky holds", 1, 1'b1);
        expect_all("R2 rise");
        clear_all();
    endtask

    task automatic t_fall();
        trig[2] = 1'b1; tick();
        expect_bit("R3 no set on rise", 2, 1'b0);
        trig[2] = 1'b0; tick();
        expect_bit("R3 fall sets", 2, 1'b1);
        expect_all("R3 fall");
        clear_all();
    endtask

    task automatic t_both();
        trig[3] = 1'b1; trig[7] = 1'b1; tick();
        expect_bit("R4 both rise", 3, 1'b1);
        wr_en = 1'b1; wr_data = 16'h0008; wr_be = 2'b01; tick();
        wr_en = 1'b0;
        expect_bit("R4 cleared", 3, 1'b0);
        trig[3] = 1'b0; trig[7] = 1'b0; tick();
        expect_bit("R4 both fall", 3, 1'b1);
        expect_bit("R4 both fall transparent", 7, 1'b1);
        expect_all("R4 both");
        clear_all();
    endtask

    task automatic t_level();
        trig[0] = 1'b1; trig[4] = 1'b1; tick(2);
        expect_bit("R5 level sets", 0, 1'b1);
        expect_bit("R5 level transparent", 4, 1'b1);
        trig[0] = 1'b0; trig[4] = 1'b0; tick();
        expect_bit("R6 level sticky holds", 0, 1'b1);
        expect_bit("R7 level transparent follows", 4, 1'b0);
        expect_all("R5 level");
        clear_all();
    endtask

    task automatic t_w1c();
        trig[0] = 1'b1; trig[1] = 1'b1; trig[8] = 1'b1; tick();
        trig = '0; tick();
        wr_en = 1'b1; wr_data = 16'hFFFD; wr_be = 2'b01; tick();
        wr_en = 1'b0; wr_be = '0;
        expect_bit("R8 written bit cleared", 0, 1'b0);
        expect_bit("R8 zero data bit kept", 1, 1'b1);
        expect_bit("R8 disabled byte kept", 8, 1'b1);
        expect_all("R8 w1c");
        clear_all();
    endtask

    task automatic t_priority();
        trig[0] = 1'b1; tick();
        wr_en = 1'b1; wr_data = 16'h0001; wr_be = 2'b01; tick();
        wr_en = 1'b0;
        expect_bit("R9 set wins over clear", 0, 1'b1);
        trig[4] = 1'b1; tick();
        wr_en = 1'b1; wr_data = 16'h0010; wr_be = 2'b01; tick();
        wr_en = 1'b0;
        expect_bit("R7 write ignored on transparent", 4, 1'b1);
        expect_all("R9 priority");
        clear_all();
    endtask

    task automatic t_qual();
        trig[0] = 1'b1; tick(); trig = '0; tick();
        qual = 16'h0001; #1;
        expect_sig("R10 mask blocks", irq, 1'b0);
        qual = 16'h0000; #1;
        expect_sig("R12 mask release no clock", irq, 1'b1);
        clear_all();
        trig[1] = 1'b1; tick(); trig = '0; tick();
        qual = 16'h0000; #1;
        expect_sig("R10 enable low blocks", irq, 1'b0);
        qual = 16'h0002; #1;
        expect_sig("R10 enable high passes", irq, 1'b1);
        expect_all("R10 qual");
        qual = '0;
        clear_all();
    endtask

    task automatic t_halt();
        trig[9] = 1'b1; tick(); trig = '0; tick();
        halt_mask = 16'h0200; #1;
        expect_sig("R11 halt masked", halt, 1'b0);
        halt_mask = 16'hFDFF; #1;
        expect_sig("R12 halt unmasked no clock", halt, 1'b1);
        expect_all("R11 halt");
        halt_mask = '0;
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_w1c();
        t_priority();
        t_qual();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule